// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block computes everything a processor core needs to enter an interrupt or a software-trap handler. The core has two instruction states: a wide one with 4-byte instructions and a narrow one with 2-byte instructions. Each cycle the block samples the live status word, the program counter, an interrupt request and a trap request.

When a request is accepted, one clock later the block presents a full set of results. These are the handler mode, a strobe that tells the banked register file to swap, the status word to save, the link value, the handler program counter and the rewritten status word. A single-cycle done pulse marks them.

The surrounding core writes these values into its register storage. It then feeds the rewritten status back on the next cycle. Register storage, instruction fetch and handler return are handled elsewhere.

Top module: `exc_entry_seq`

## Requirements
- R1: While bit 7 (interrupt mask) of `status_i` is 1, an interrupt request alone causes no `done_o` pulse and leaves every registered output unchanged.
- R2: An accepted interrupt sets `mode_o` to 5'h12; an accepted trap sets `mode_o` to 5'h13.
- R3: On an accepted interrupt, `link_o` equals `pc_i` minus the instruction width plus 4.
- R4: On an accepted trap, `link_o` equals `pc_i` minus the instruction width.
- R5: The instruction width is 2 when bit 5 (narrow state) of `status_i` is 1, and 4 when it is 0.
- R6: On entry, `saved_status_o` equals the `status_i` value sampled with the request.
- R7: On entry, `status_o` equals the sampled status with bits 4:0 replaced by the new mode, bit 5 cleared and bit 7 set; all other bits are kept.
- R8: On entry, `pc_o` is 0x0C for a trap and 0x1C for an interrupt (vector 0x08 or 0x18, plus 4 for prefetch).
- R9: When both requests arrive in the same cycle, the trap is taken. Once the rewritten status is fed back, the still-asserted interrupt request is ignored.
- R10: `done_o` rises exactly one cycle after the edge that accepts a request. It stays high for one cycle per accepted request.
- R11: `bank_switch_o` pulses together with `done_o`, and only when the new mode differs from the sampled bits 4:0.
- R12: After reset, `done_o` and `bank_switch_o` are 0 and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 32 | Current status word: bits 4:0 mode, bit 5 narrow state, bit 7 interrupt mask |
| pc_i | input | 32 | Current program counter |
| irq_req_i | input | 1 | Interrupt request |
| trap_req_i | input | 1 | Software-trap request |
| mode_o | output | 5 | Handler mode |
| bank_switch_o | output | 1 | Banked register swap strobe |
| saved_status_o | output | 32 | Status word to store as saved status |
| link_o | output | 32 | Link register value |
| pc_o | output | 32 | Handler program counter |
| status_o | output | 32 | Rewritten status word |
| done_o | output | 1 | One-cycle entry-complete pulse |

## Verification
Two functions can fall in the same cycle: trap entry and interrupt entry. The bench provokes this by raising both requests together across every combination of state, mask and prior mode. It then checks that the trap's mode, link and vector win.

Next it feeds `status_o` back as the live status while the interrupt request stays high. The bench judges the collision resolved when no second done pulse follows.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_TRAP = 2'd1,
    EXC_IRQ  = 2'd2
  } exc_kind_e;
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MASK_BIT = 7
) (
  input  logic [XLEN-1:0] status_i,
  input  logic            irq_req_i,
  input  logic            trap_req_i,
  output exc_kind_e       kind_o
);
  logic irq_ok;
  assign irq_ok = irq_req_i & ~status_i[MASK_BIT];

  // trap outranks interrupt
  always_comb begin
    if (trap_req_i)  kind_o = EXC_TRAP;
    else if (irq_ok) kind_o = EXC_IRQ;
    else             kind_o = EXC_NONE;
  end
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MODE_W    = 5,
  parameter int STATE_BIT = 5,
  parameter int MASK_BIT  = 7,
  parameter int MODE_IRQ  = 18,
  parameter int MODE_SVC  = 19,
  parameter int VEC_TRAP  = 8,
  parameter int VEC_IRQ   = 24,
  parameter int PREFETCH  = 4
) (
  input  exc_kind_e         kind_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [XLEN-1:0]   link_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   status_o,
  output logic              mode_change_o
);
  localparam logic [XLEN-1:0]   WIDTH_NARROW = XLEN'(2);
  localparam logic [XLEN-1:0]   WIDTH_WIDE   = XLEN'(4);
  localparam logic [XLEN-1:0]   ADJ_IRQ      = XLEN'(PREFETCH);
  localparam logic [XLEN-1:0]   PC_TRAP      = XLEN'(VEC_TRAP + PREFETCH);
  localparam logic [XLEN-1:0]   PC_IRQ       = XLEN'(VEC_IRQ + PREFETCH);
  localparam logic [MODE_W-1:0] M_IRQ        = MODE_W'(MODE_IRQ);
  localparam logic [MODE_W-1:0] M_SVC        = MODE_W'(MODE_SVC);

  logic [XLEN-1:0] insn_w;
  logic [XLEN-1:0] base_ret;
  logic            is_irq;

  assign is_irq   = (kind_i == EXC_IRQ);
  assign insn_w   = status_i[STATE_BIT] ? WIDTH_NARROW : WIDTH_WIDE;
  assign base_ret = pc_i - insn_w;

  always_comb begin
    mode_o = is_irq ? M_IRQ : M_SVC;
    link_o = is_irq ? base_ret + ADJ_IRQ : base_ret;
    pc_o   = is_irq ? PC_IRQ : PC_TRAP;
    status_o = status_i;
    status_o[MODE_W-1:0] = mode_o;
    status_o[STATE_BIT]  = 1'b0;
    status_o[MASK_BIT]   = 1'b1;
  end

  assign mode_change_o = (mode_o != status_i[MODE_W-1:0]);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MODE_W    = 5,
  parameter int STATE_BIT = 5,
  parameter int MASK_BIT  = 7,
  parameter int MODE_IRQ  = 18,
  parameter int MODE_SVC  = 19,
  parameter int VEC_TRAP  = 8,
  parameter int VEC_IRQ   = 24,
  parameter int PREFETCH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              irq_req_i,
  input  logic              trap_req_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              bank_switch_o,
  output logic [XLEN-1:0]   saved_status_o,
  output logic [XLEN-1:0]   link_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   status_o,
  output logic              done_o
);
  localparam logic [MODE_W-1:0] M_IRQ = MODE_W'(MODE_IRQ);
  localparam logic [MODE_W-1:0] M_SVC = MODE_W'(MODE_SVC);

  exc_kind_e         kind;
  logic              take;
  logic [MODE_W-1:0] nx_mode;
  logic [XLEN-1:0]   nx_link, nx_pc, nx_status;
  logic              nx_switch;

  exc_select #(.XLEN(XLEN), .MASK_BIT(MASK_BIT)) u_sel (
    .status_i  (status_i),
    .irq_req_i (irq_req_i),
    .trap_req_i(trap_req_i),
    .kind_o    (kind)
  );

  exc_target_calc #(
    .XLEN(XLEN), .MODE_W(MODE_W), .STATE_BIT(STATE_BIT), .MASK_BIT(MASK_BIT),
    .MODE_IRQ(MODE_IRQ), .MODE_SVC(MODE_SVC), .VEC_TRAP(VEC_TRAP),
    .VEC_IRQ(VEC_IRQ), .PREFETCH(PREFETCH)
  ) u_calc (
    .kind_i       (kind),
    .status_i     (status_i),
    .pc_i         (pc_i),
    .mode_o       (nx_mode),
    .link_o       (nx_link),
    .pc_o         (nx_pc),
    .status_o     (nx_status),
    .mode_change_o(nx_switch)
  );

  assign take = (kind != EXC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      bank_switch_o <= 1'b0;
    end else begin
      done_o        <= take;
      bank_switch_o <= take & nx_switch;
    end
  end

  // data regs load only on accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o         <= '0;
      saved_status_o <= '0;
      link_o         <= '0;
      pc_o           <= '0;
      status_o       <= '0;
    end else if (take) begin
      mode_o         <= nx_mode;
      saved_status_o <= status_i;
      link_o         <= nx_link;
      pc_o           <= nx_pc;
      status_o       <= nx_status;
    end
  end

  AST_MASKED_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !trap_req_i && status_i[MASK_BIT]) |=> (!done_o && $stable(link_o))) // R1
    else $error("masked irq accepted");
  AST_IRQ_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !trap_req_i && !status_i[MASK_BIT]) |=> (done_o && mode_o == M_IRQ)) // R2
    else $error("irq mode wrong");
  AST_TRAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i |=> (done_o && mode_o == M_SVC && pc_o == XLEN'(VEC_TRAP + PREFETCH))) // R9
    else $error("trap not prioritized");
  AST_SAVED_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i || (irq_req_i && !status_i[MASK_BIT])) |=> (saved_status_o == $past(status_i))) // R6
    else $error("saved status mismatch");
  AST_STATUS_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o[MASK_BIT] && !status_o[STATE_BIT] && status_o[MODE_W-1:0] == mode_o)) // R7
    else $error("status not forced");
  AST_SWITCH_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_switch_o |-> done_o) // R11
    else $error("switch without done");
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_req_i && !(irq_req_i && !status_i[MASK_BIT])) |=> !done_o) // R10
    else $error("spurious done");
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] status_i = '0;
  logic [31:0] pc_i = '0;
  logic        irq_req = 1'b0;
  logic        trap_req = 1'b0;
  logic [4:0]  mode_o;
  logic        bank_switch_o;
  logic [31:0] saved_status_o, link_o, pc_o, status_o;
  logic        done_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .status_i(status_i), .pc_i(pc_i),
    .irq_req_i(irq_req), .trap_req_i(trap_req), .mode_o(mode_o),
    .bank_switch_o(bank_switch_o), .saved_status_o(saved_status_o),
    .link_o(link_o), .pc_o(pc_o), .status_o(status_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [4:0]  modes [4] = '{5'h10, 5'h12, 5'h13, 5'h1F};
    logic [31:0] pcs   [4] = '{32'h0000_0008, 32'h0000_1002, 32'h8000_0000, 32'hFFFF_FFFC};
    logic [31:0] st, exp_st, w, exp_link, prev_link, prev_pc;
    logic [4:0]  exp_mode;
    logic        irq_k, trap_k, accepted;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 done", {31'b0, done_o}, 32'h0);
    chk("R12 switch", {31'b0, bank_switch_o}, 32'h0);
    chk("R12 link", link_o, 32'h0);
    chk("R12 pc", pc_o, 32'h0);
    chk("R12 status", status_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 3; k++) begin
      for (int th = 0; th < 2; th++) begin
        for (int mk = 0; mk < 2; mk++) begin
          for (int mi = 0; mi < 4; mi++) begin
            for (int pi = 0; pi < 4; pi++) begin
              irq_k  = (k != 1);
              trap_k = (k != 0);
              st = 32'hA500_0040 | (32'(mk) << 7) | (32'(th) << 5) | 32'(modes[mi]);
              prev_link = link_o;
              prev_pc   = pc_o;
              status_i = st;
              pc_i     = pcs[pi];
              irq_req  = irq_k;
              trap_req = trap_k;
              @(negedge clk);
              accepted = trap_k || (irq_k && mk == 0);
              w = (th == 1) ? 32'd2 : 32'd4;                  // R5
              if (!accepted) begin
                chk("R1 done", {31'b0, done_o}, 32'h0);
                chk("R1 link", link_o, prev_link);
                chk("R1 pc", pc_o, prev_pc);
              end else begin
                exp_mode = trap_k ? 5'h13 : 5'h12;
                exp_link = trap_k ? pcs[pi] - w : pcs[pi] - w + 32'd4;
                exp_st = (st & ~32'h0000_00BF) | 32'h80 | 32'(exp_mode);
                chk("R10 done", {31'b0, done_o}, 32'h1);
                chk(trap_k ? "R9 R2 mode" : "R2 mode", {27'b0, mode_o}, {27'b0, exp_mode});
                chk(trap_k ? "R4 R5 link" : "R3 R5 link", link_o, exp_link);
                chk("R8 pc", pc_o, trap_k ? 32'h0C : 32'h1C);
                chk("R6 saved", saved_status_o, st);
                chk("R7 status", status_o, exp_st);
                chk("R11 switch", {31'b0, bank_switch_o}, {31'b0, exp_mode != modes[mi]});
              end
              if (k == 2) begin
                // R9 feed back rewritten status, irq still high
                status_i = status_o;
                trap_req = 1'b0;
                prev_link = link_o;
                @(negedge clk);
                chk("R9 pending irq masked", {31'b0, done_o}, 32'h0);
                chk("R9 link held", link_o, prev_link);
              end
              irq_req = 1'b0;
              trap_req = 1'b0;
              @(negedge clk);
              chk("R10 single pulse", {31'b0, done_o}, 32'h0);
              chk("R11 switch low", {31'b0, bank_switch_o}, 32'h0);
            end
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule